// File: doc/BRIEF.md
# Reconfigurable Three-Stage Pipeline Admission Controller

This controller schedules work onto a three-stage arithmetic pipeline whose stages are revisited through feedback and feed-forward paths. Two operation kinds, function A and function B, each follow their own fixed route through the stages over six cycles. Requests arrive on a valid/ready handshake with a function bit and an operation id. Each cycle the controller decides whether the presented request may start. It reports which operation holds each stage and which source each stage's input multiplexer must pick. It also flags each finished operation on the result port that belongs to its function. The stage arithmetic is not part of the block; the stages are tracked only as tagged occupancy.

A reservation bitmap holds, for every stage, the six cycles ahead. A request is admitted when its own reservation pattern does not overlap the bitmap. On admission the pattern is merged into the bitmap. In dynamic mode operations of both functions may share the pipeline. In static mode a state machine keeps a single active configuration and drains the pipeline before switching to the other function.

The state machine has three states. RUN admits requests. DRAIN waits for the pipeline to empty. RECONF spends one cycle switching the active function. Its transitions are: RUN to DRAIN (mismatch seen), DRAIN to RECONF (drained), DRAIN to RUN (dynamic selected), RECONF to RUN (switched).

Top module: `mfpipe_ctrl`

## Requirements
- R1: A synchronous reset leaves every stage idle with no result flagged, sets the active static function to A, and puts the machine in RUN. Right after reset, req_ready is high for a function-A request and low for a function-B request while static mode is selected.
- R2: An operation accepted in cycle c holds one stage in each of cycles c+1 to c+6. Stage index 0 is Sa, 1 is Sb and 2 is Sc. Function A visits Sa, Sb, Sb, Sc, Sc, Sa in that order. Function B visits Sa, Sc, Sb, Sa, Sb, Sc. No stage is ever held by two operations in the same cycle.
- R3: For each stage, stg_busy is high in exactly the cycles the stage is held. While it is high, the stage's id field (bits s*ID_W upward) carries the owner's id and stg_func carries its function (0 = A, 1 = B). Idle stages show zero id and zero function.
- R4: For each held stage, the 2-bit select (bits 2s+1:2s) is 0 in the owner's first slot, meaning the external input. In any later slot it is 1 plus the index of the stage the owner used in the previous cycle. Idle stages show 0.
- R5: A function-A operation accepted in cycle c raises res_a_valid with its id in cycle c+6. A function-B operation raises res_b_valid with its id in cycle c+6. The other result port stays low.
- R6: In dynamic mode, req_ready is high exactly when no slot of the requested function overlaps a stage-cycle already reserved. Functions may be mixed. With a single prior operation accepted d cycles earlier, the refused spacings are: {1,5} for A after A, {2,3,5} for B after A, {1,2,3} for A after B, and {2,3,4} for B after B.
- R7: In static mode in RUN, a request of the active function is admitted under the same overlap rule as R6.
- R8: In static mode, a valid request of the other function sees req_ready low and moves RUN to DRAIN. DRAIN holds req_ready low until a cycle in which no reservation lies beyond the current cycle, then moves to RECONF. RECONF holds req_ready low for one cycle, flips the active function and returns to RUN.
- R9: If dynamic mode is selected while in DRAIN, the machine returns to RUN on the next cycle. req_ready stays low during DRAIN and RECONF.
- R10: A reset asserted while operations are in flight discards them. No stage is busy and no result appears afterwards until new operations are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dyn_mode | input | 1 | 1 = dynamic (mixed functions), 0 = static |
| req_valid | input | 1 | Request present |
| req_func | input | 1 | Requested function, 0 = A, 1 = B |
| req_id | input | ID_W | Operation id |
| req_ready | output | 1 | Request may start this cycle |
| stg_busy | output | 3 | Per-stage held flag |
| stg_func | output | 3 | Per-stage owner function |
| stg_id | output | 3*ID_W | Per-stage owner id |
| stg_sel | output | 6 | Per-stage input multiplexer select |
| res_a_valid | output | 1 | Function-A result completes |
| res_a_id | output | ID_W | Id of completing A operation |
| res_b_valid | output | 1 | Function-B result completes |
| res_b_id | output | ID_W | Id of completing B operation |

## Verification
The hardest condition to reach from the ports is a request arriving at a spacing where its pattern lands exactly on a previous operation's later revisit of a stage. Examples are the return to Sa five cycles into function A and the Sc/Sb crossings between the two functions. The bench reaches every such case by sweeping both functions for the first operation, both for the second, and every spacing from one to seven cycles, starting each time from an empty pipeline. The static drain path is reached by streaming one function and then presenting the other, including a switch to dynamic mode while the drain is still pending.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
    localparam int NSTG  = 3;
    localparam int SPAN  = 6;
    localparam int SEL_W = 2;
    localparam int SW    = $clog2(NSTG);

    typedef enum logic { FN_A = 1'b0, FN_B = 1'b1 } fn_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_RECONF = 2'd2
    } mode_st_e;

    typedef logic [NSTG-1:0][SPAN-1:0] rmap_t;

    // stage visited by function f in slot t
    function automatic logic [SW-1:0] slot_stage(fn_e f, int t);
        logic [SW-1:0] s;
        if (f == FN_A) begin
            case (t)
                0:       s = 2'd0;
                1, 2:    s = 2'd1;
                3, 4:    s = 2'd2;
                default: s = 2'd0;
            endcase
        end else begin
            case (t)
                0:       s = 2'd0;
                1:       s = 2'd2;
                2:       s = 2'd1;
                3:       s = 2'd0;
                4:       s = 2'd1;
                default: s = 2'd2;
            endcase
        end
        return s;
    endfunction

    function automatic rmap_t rsv_pattern(fn_e f);
        rmap_t r;
        r = '0;
        for (int t = 0; t < SPAN; t++) r[slot_stage(f, t)][t] = 1'b1;
        return r;
    endfunction

    // input mux source: 0 external, else 1 + previous stage
    function automatic logic [SEL_W-1:0] src_sel(fn_e f, int t);
        if (t == 0) return '0;
        return SEL_W'(slot_stage(f, t - 1)) + SEL_W'(1);
    endfunction
endpackage

// File: rtl/mfp_rsv_map.sv
module mfp_rsv_map
    import mfp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  fn_e             req_func,
    input  logic            accept,
    output logic            clear_ok,
    output logic            idle_ahead,
    output logic [NSTG-1:0] nxt_busy
);
    rmap_t occ;
    rmap_t want;
    rmap_t merged;

    always_comb want = rsv_pattern(req_func);
    always_comb clear_ok = ((occ & want) == '0);
    always_comb idle_ahead = (occ == '0);
    always_comb merged = accept ? (occ | want) : occ;

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_nb
            assign nxt_busy[s] = merged[s][0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            for (int s = 0; s < NSTG; s++) occ[s] <= merged[s] >> 1;
        end
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> ((occ & want) == '0));
endmodule

// File: rtl/mfp_mode_fsm.sv
module mfp_mode_fsm
    import mfp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dyn_mode,
    input  logic req_valid,
    input  fn_e  req_func,
    input  logic clear_ok,
    input  logic idle_ahead,
    output logic req_ready
);
    mode_st_e st;
    mode_st_e st_nx;
    fn_e      cfg;
    logic     armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_RUN;
            cfg   <= FN_A;
            armed <= 1'b0;
        end else begin
            st    <= st_nx;
            armed <= 1'b1;
            if (st == ST_RECONF) cfg <= fn_e'(~cfg);
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_RUN:    if (!dyn_mode && req_valid && (req_func != cfg)) st_nx = ST_DRAIN;
            ST_DRAIN:  if (dyn_mode) st_nx = ST_RUN;
                       else if (idle_ahead) st_nx = ST_RECONF;
            ST_RECONF: st_nx = ST_RUN;
            default:   st_nx = ST_RUN;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        unique case (st)
            ST_RUN:    req_ready = clear_ok && (dyn_mode || (req_func == cfg));
            ST_DRAIN:  req_ready = 1'b0;
            ST_RECONF: req_ready = 1'b0;
            default:   req_ready = 1'b0;
        endcase
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cfg != $past(cfg)) |-> ($past(st) == ST_RECONF));
endmodule

// File: rtl/mfp_stage_track.sv
module mfp_stage_track
    import mfp_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  fn_e                  acc_func,
    input  logic [ID_W-1:0]      acc_id,
    output logic [NSTG-1:0]      busy,
    output logic [NSTG-1:0]      func,
    output logic [NSTG*ID_W-1:0] owner_id,
    output logic [NSTG*SEL_W-1:0] sel,
    output logic                 res_a_valid,
    output logic [ID_W-1:0]      res_a_id,
    output logic                 res_b_valid,
    output logic [ID_W-1:0]      res_b_id
);
    typedef struct packed {
        logic            v;
        fn_e             f;
        logic [ID_W-1:0] id;
    } slot_t;

    // hist[t] holds the operation accepted t+1 cycles ago
    slot_t hist [SPAN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SPAN; k++) hist[k] <= '0;
        end else begin
            hist[0] <= '{v: accept, f: acc_func, id: acc_id};
            for (int k = 1; k < SPAN; k++) hist[k] <= hist[k-1];
        end
    end

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stg
            logic [SPAN-1:0]  hit;
            logic             b_loc;
            logic             f_loc;
            logic [ID_W-1:0]  i_loc;
            logic [SEL_W-1:0] m_loc;

            always_comb begin
                for (int t = 0; t < SPAN; t++)
                    hit[t] = hist[t].v && (slot_stage(hist[t].f, t) == SW'(s));
            end

            always_comb begin
                b_loc = 1'b0;
                f_loc = 1'b0;
                i_loc = '0;
                m_loc = '0;
                for (int t = 0; t < SPAN; t++) begin
                    if (hit[t]) begin
                        b_loc = 1'b1;
                        f_loc = hist[t].f;
                        i_loc = hist[t].id;
                        m_loc = src_sel(hist[t].f, t);
                    end
                end
            end

            assign busy[s]                     = b_loc;
            assign func[s]                     = f_loc;
            assign owner_id[s*ID_W +: ID_W]    = i_loc;
            assign sel[s*SEL_W +: SEL_W]       = m_loc;

            // R2
            one_owner_chk: assert property (@(posedge clk) disable iff (rst)
                $onehot0(hit));
        end
    endgenerate

    assign res_a_valid = hist[SPAN-1].v && (hist[SPAN-1].f == FN_A);
    assign res_b_valid = hist[SPAN-1].v && (hist[SPAN-1].f == FN_B);
    assign res_a_id    = res_a_valid ? hist[SPAN-1].id : '0;
    assign res_b_id    = res_b_valid ? hist[SPAN-1].id : '0;

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy == '0) && !res_a_valid && !res_b_valid);
endmodule

// File: rtl/mfpipe_ctrl.sv
module mfpipe_ctrl
    import mfp_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dyn_mode,
    input  logic                  req_valid,
    input  logic                  req_func,
    input  logic [ID_W-1:0]       req_id,
    output logic                  req_ready,
    output logic [NSTG-1:0]       stg_busy,
    output logic [NSTG-1:0]       stg_func,
    output logic [NSTG*ID_W-1:0]  stg_id,
    output logic [NSTG*SEL_W-1:0] stg_sel,
    output logic                  res_a_valid,
    output logic [ID_W-1:0]       res_a_id,
    output logic                  res_b_valid,
    output logic [ID_W-1:0]       res_b_id
);
    fn_e             rf;
    logic            accept;
    logic            clear_ok;
    logic            idle_ahead;
    logic [NSTG-1:0] nxt_busy;
    logic            armed;

    assign rf     = fn_e'(req_func);
    assign accept = req_valid && req_ready;

    mfp_rsv_map u_map (
        .clk        (clk),
        .rst        (rst),
        .req_func   (rf),
        .accept     (accept),
        .clear_ok   (clear_ok),
        .idle_ahead (idle_ahead),
        .nxt_busy   (nxt_busy)
    );

    mfp_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .dyn_mode   (dyn_mode),
        .req_valid  (req_valid),
        .req_func   (rf),
        .clear_ok   (clear_ok),
        .idle_ahead (idle_ahead),
        .req_ready  (req_ready)
    );

    mfp_stage_track #(.ID_W(ID_W)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .acc_func    (rf),
        .acc_id      (req_id),
        .busy        (stg_busy),
        .func        (stg_func),
        .owner_id    (stg_id),
        .sel         (stg_sel),
        .res_a_valid (res_a_valid),
        .res_a_id    (res_a_id),
        .res_b_valid (res_b_valid),
        .res_b_id    (res_b_id)
    );

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R2
    busy_match_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        stg_busy == $past(nxt_busy));

    // R5
    res_a_chk: assert property (@(posedge clk) disable iff (rst)
        res_a_valid |-> (stg_busy[0] && (stg_func[0] == 1'b0)));

    // R5
    res_b_chk: assert property (@(posedge clk) disable iff (rst)
        res_b_valid |-> (stg_busy[2] && (stg_func[2] == 1'b1)));
endmodule

// File: tb/mfpipe_ctrl_bench.sv
module mfpipe_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int IDW   = 4;
    localparam int MAXC  = 4096;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           dyn_mode = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_func = 1'b0;
    logic [IDW-1:0] req_id = '0;
    logic           req_ready;
    logic [2:0]     stg_busy, stg_func;
    logic [3*IDW-1:0] stg_id;
    logic [5:0]     stg_sel;
    logic           res_a_valid, res_b_valid;
    logic [IDW-1:0] res_a_id, res_b_id;

    mfpipe_ctrl #(.ID_W(IDW)) u_mfpipe_ctrl (
        .clk(clk), .rst(rst), .dyn_mode(dyn_mode), .req_valid(req_valid),
        .req_func(req_func), .req_id(req_id), .req_ready(req_ready),
        .stg_busy(stg_busy), .stg_func(stg_func), .stg_id(stg_id), .stg_sel(stg_sel),
        .res_a_valid(res_a_valid), .res_a_id(res_a_id),
        .res_b_valid(res_b_valid), .res_b_id(res_b_id)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int c_id [3][MAXC];
    int c_fn [3][MAXC];
    int c_sel[3][MAXC];
    int ra[MAXC];
    int rb[MAXC];
    int m_st = 0;
    int m_cfg = 0;
    bit last_acc;
    bit seen_ready;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // R2 slot orders: A = Sa Sb Sb Sc Sc Sa, B = Sa Sc Sb Sa Sb Sc
    function automatic int bstage(int f, int t);
        int a[6] = '{0, 1, 1, 2, 2, 0};
        int b[6] = '{0, 2, 1, 0, 1, 2};
        return (f == 0) ? a[t] : b[t];
    endfunction

    task automatic clear_from(input int c0);
        for (int c = c0; c < MAXC; c++) begin
            for (int s = 0; s < 3; s++) begin
                c_id[s][c] = -1; c_fn[s][c] = 0; c_sel[s][c] = 0;
            end
            ra[c] = -1; rb[c] = -1;
        end
    endtask

    task automatic step(input bit v, input int f, input int id, input bit dyn);
        bit fb, conf, er;
        string rtag;
        @(negedge clk);
        req_valid = v; req_func = f[0]; req_id = id[IDW-1:0]; dyn_mode = dyn;
        #1;
        fb = 0; conf = 0;
        for (int t = 0; t < 6; t++) begin
            for (int s = 0; s < 3; s++) if (c_id[s][cyc+1+t] != -1) fb = 1;
            if (c_id[bstage(f, t)][cyc+1+t] != -1) conf = 1;
        end
        er = (m_st == 0) && (dyn || f == m_cfg) && !conf;
        if (m_st != 0) rtag = dyn ? "R9" : "R8";
        else rtag = dyn ? "R6" : ((f == m_cfg) ? "R7" : "R8");
        seen_ready = req_ready;
        chk(req_ready == er, rtag, int'(req_ready), int'(er));
        for (int s = 0; s < 3; s++) begin
            bit eb;
            eb = (c_id[s][cyc] != -1);
            chk(stg_busy[s] == eb, "R2", int'(stg_busy[s]), int'(eb));
            chk(int'(stg_id[s*IDW +: IDW]) == (eb ? c_id[s][cyc] : 0), "R3",
                int'(stg_id[s*IDW +: IDW]), eb ? c_id[s][cyc] : 0);
            chk(int'(stg_func[s]) == c_fn[s][cyc], "R3", int'(stg_func[s]), c_fn[s][cyc]);
            chk(int'(stg_sel[s*2 +: 2]) == c_sel[s][cyc], "R4",
                int'(stg_sel[s*2 +: 2]), c_sel[s][cyc]);
        end
        chk(res_a_valid == (ra[cyc] != -1) && (ra[cyc] == -1 || int'(res_a_id) == ra[cyc]),
            "R5", res_a_valid ? int'(res_a_id) : -1, ra[cyc]);
        chk(res_b_valid == (rb[cyc] != -1) && (rb[cyc] == -1 || int'(res_b_id) == rb[cyc]),
            "R5", res_b_valid ? int'(res_b_id) : -1, rb[cyc]);
        last_acc = v && er;
        if (last_acc) begin
            for (int t = 0; t < 6; t++) begin
                c_id [bstage(f, t)][cyc+1+t] = id;
                c_fn [bstage(f, t)][cyc+1+t] = f;
                c_sel[bstage(f, t)][cyc+1+t] = (t == 0) ? 0 : bstage(f, t-1) + 1;
            end
            if (f == 0) ra[cyc+6] = id; else rb[cyc+6] = id;
        end
        if (m_st == 0) begin
            if (!dyn && v && f != m_cfg) m_st = 1;
        end else if (m_st == 1) begin
            if (dyn) m_st = 0; else if (!fb) m_st = 2;
        end else begin
            m_cfg = 1 - m_cfg; m_st = 0;
        end
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; req_valid = 0; dyn_mode = 0;
        clear_from(cyc);
        cyc++;
        @(negedge clk);
        cyc++;
        @(negedge clk);
        rst = 0; req_func = 1'b1;
        m_st = 0; m_cfg = 0;
        #1;
        // R1: idle, static, function B refused
        chk(stg_busy == 3'b000, "R1", int'(stg_busy), 0);
        chk(!res_a_valid && !res_b_valid, "R1", int'({res_a_valid, res_b_valid}), 0);
        chk(req_ready == 1'b0, "R1", int'(req_ready), 0);
        req_func = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        cyc++;
    endtask

    task automatic issue(input int f, input int id, input bit dyn);
        int tries = 0;
        do begin
            step(1, f, id, dyn);
            tries++;
        end while (!last_acc && tries < 60);
        if (!last_acc) chk(0, dyn ? "R6" : "R8", tries, 0);
    endtask

    task automatic idle(input int n, input bit dyn);
        for (int i = 0; i < n; i++) step(0, 0, 0, dyn);
    endtask

    function automatic int pick();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return int'(lfsr[0]);
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog R6 R8: run did not end, actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // refused spacings (R6): bit d set = refused, index [first][second]
        int mask[2][2];
        mask[0][0] = 34; mask[0][1] = 44; mask[1][0] = 14; mask[1][1] = 28;
        clear_from(0);
        do_reset();

        // R6: pairwise spacing sweep in dynamic mode
        for (int fx = 0; fx < 2; fx++)
            for (int fy = 0; fy < 2; fy++)
                for (int d = 1; d <= 7; d++) begin
                    bit exp_ok;
                    step(1, fx, 3, 1'b1);
                    idle(d - 1, 1'b1);
                    step(1, fy, 9, 1'b1);
                    exp_ok = !mask[fx][fy][d];
                    chk(seen_ready == exp_ok, "R6", int'(seen_ready), int'(exp_ok));
                    idle(8, 1'b1);
                end

        // R6/R5: mixed dynamic stream
        for (int i = 0; i < 40; i++) issue(pick(), i % 16, 1'b1);
        idle(8, 1'b1);

        // R7/R8: static streams with function switches
        for (int i = 0; i < 6; i++) issue(0, i, 1'b0);
        for (int i = 0; i < 6; i++) issue(1, 6 + i, 1'b0);
        for (int i = 0; i < 4; i++) issue(0, 12 + i, 1'b0);
        idle(8, 1'b0);

        // R9: dynamic selected while a drain is pending
        for (int i = 0; i < 3; i++) issue(0, i, 1'b0);
        step(1, 1, 5, 1'b0);
        step(1, 1, 5, 1'b0);
        issue(1, 5, 1'b1);
        issue(0, 7, 1'b1);
        idle(8, 1'b1);

        // R10: reset with operations in flight
        issue(0, 1, 1'b1);
        issue(1, 2, 1'b1);
        step(0, 0, 0, 1'b1);
        do_reset();
        for (int i = 0; i < 8; i++) begin
            step(0, 0, 0, 1'b1);
            chk(stg_busy == 3'b000, "R10", int'(stg_busy), 0);
            chk(!res_a_valid && !res_b_valid, "R10", int'({res_a_valid, res_b_valid}), 0);
        end
        issue(1, 4, 1'b1);
        idle(8, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule